// File: doc/BRIEF.md
# Variable-Length Instruction Byte Parser

This block takes the instruction byte stream of a 16-bit segmented processor front end, one byte per cycle under a valid/ready handshake, and splits each instruction into its parts: the leading operation byte, the optional addressing byte (mode, register and register/memory fields), zero to two displacement bytes and zero to two immediate bytes. From the operation byte and the two mode bits of the addressing byte it works out which of six instruction formats applies and how many bytes the instruction spans, from 1 to 6.

When the last byte of an instruction has been taken, the parser presents a complete record: format code, length, the raw operation and addressing bytes, a 16-bit displacement and a 16-bit immediate, assembled low byte first. The record stays on the outputs until the consumer takes it. While it waits, the parser refuses further bytes. A small built-in class table, set by the upper three bits of the operation byte, decides whether an addressing byte and immediate data follow.

Top module: `instr_byte_parser`

## Requirements
- R1: A synchronous reset, including one in the middle of an instruction, leaves `in_ready`=1 and `rec_valid`=0, and the next byte taken is treated as an operation byte.
- R2: The class comes from operation-byte bits [7:5]: 000 or 001 means an addressing byte follows; 100 or 101 means an addressing byte plus immediate data; 010 means a one-byte form with a register in bits [2:0]; 011, 110 and 111 mean a one-byte form with implied operands. For the two classes with an addressing byte, `rec_wide` equals operation-byte bit 0; otherwise it is 0.
- R3: A one-byte form gives a record right after that byte with `rec_fmt`=1, `rec_len`=1, and zero addressing, displacement and immediate fields. `rec_opreg_en`=1 and `rec_opreg`=bits [2:0] only for the register class.
- R4: In the addressing-byte class, the mode field is bits [7:6] of the second byte: mode 11 gives format 2, length 2; mode 00 gives format 3, length 2; mode 01 gives format 4, length 3; mode 10 gives format 4, length 4.
- R5: Displacement bytes follow the addressing byte, low byte first. Mode 01 carries one byte, sign-extended to 16 bits. Mode 10 carries two. Modes 00 and 11 carry none and give a zero displacement.
- R6: In the immediate class with mode 11, the format is 5 and one immediate byte follows when the width bit is 0, two when it is 1 (length 3 or 4). The immediate is assembled low byte first, and a single byte is zero-extended.
- R7: In the immediate class with any other mode, the format is 6. The displacement bytes of R5 come first, then the immediate bytes of R6, for a length of 2 + displacement count + immediate count.
- R8: A byte is taken only on a cycle with `in_valid` and `in_ready` both high. Idle cycles inside an instruction leave the parse unchanged, and no record appears before the last byte.
- R9: While `rec_valid` is high and `rec_ready` is low, `in_ready` stays low, bytes offered are not consumed, and every record field holds its value.
- R10: On the cycle after `rec_valid` and `rec_ready` are both high, `rec_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte is present |
| in_ready | output | 1 | Parser can take a byte |
| in_byte | input | BYTE_W | Instruction byte |
| rec_valid | output | 1 | A complete record is presented |
| rec_ready | input | 1 | Consumer takes the record |
| rec_fmt | output | 3 | Format code 1..6 |
| rec_len | output | 3 | Instruction length in bytes |
| rec_opcode | output | BYTE_W | Operation byte |
| rec_modrm | output | BYTE_W | Addressing byte, zero when absent |
| rec_disp | output | 2*BYTE_W | Displacement |
| rec_imm | output | 2*BYTE_W | Immediate data |
| rec_wide | output | 1 | Width bit of the operation byte |
| rec_opreg_en | output | 1 | One-byte form names a register |
| rec_opreg | output | 3 | Register number of the one-byte form |

## Verification
The bench runs every operation byte against every mode value and inserts idle cycles at different points inside instructions. This exposes a parser that takes the wrong number of displacement or immediate bytes: it would consume the next operation byte as data and misparse every later instruction. Single-byte displacements with the top bit set catch missing sign extension, and narrow immediates with garbage in the would-be high byte catch a missing zero extension. Held records with bytes offered during the wait catch a parser that leaks input while stalled or lets fields drift. A reset in the middle of an instruction catches a state machine that resumes its old parse.

// File: rtl/ibp_pkg.sv
package ibp_pkg;

   typedef enum logic [1:0] {
      CLS_IMPL  = 2'd0,
      CLS_OPREG = 2'd1,
      CLS_RM    = 2'd2,
      CLS_IMM   = 2'd3
   } ibp_cls_e;

   typedef enum logic [2:0] {
      ST_OPC   = 3'd0,
      ST_MODRM = 3'd1,
      ST_DLO   = 3'd2,
      ST_DHI   = 3'd3,
      ST_ILO   = 3'd4,
      ST_IHI   = 3'd5,
      ST_DONE  = 3'd6
   } ibp_state_e;

   localparam int LEN_W   = 3;
   localparam int FMT_W   = 3;
   localparam int MAX_LEN = 6;

   localparam logic [FMT_W-1:0] FMT_NONE = 3'd0;
   localparam logic [FMT_W-1:0] FMT_ONE  = 3'd1;
   localparam logic [FMT_W-1:0] FMT_RR   = 3'd2;
   localparam logic [FMT_W-1:0] FMT_RM0  = 3'd3;
   localparam logic [FMT_W-1:0] FMT_RMD  = 3'd4;
   localparam logic [FMT_W-1:0] FMT_IR   = 3'd5;
   localparam logic [FMT_W-1:0] FMT_IM   = 3'd6;

   // number of displacement bytes selected by the two mode bits
   function automatic logic [1:0] disp_count(input logic [1:0] mode);
      case (mode)
         2'b01:   disp_count = 2'd1;
         2'b10:   disp_count = 2'd2;
         default: disp_count = 2'd0;
      endcase
   endfunction

   function automatic logic [FMT_W-1:0] fmt_for(input ibp_cls_e c, input logic [1:0] mode);
      case (c)
         CLS_RM: begin
            case (mode)
               2'b11:   fmt_for = FMT_RR;
               2'b00:   fmt_for = FMT_RM0;
               default: fmt_for = FMT_RMD;
            endcase
         end
         CLS_IMM: fmt_for = (mode == 2'b11) ? FMT_IR : FMT_IM;
         default: fmt_for = FMT_ONE;
      endcase
   endfunction

endpackage

// File: rtl/ibp_classify.sv
module ibp_classify
   import ibp_pkg::*;
(
   input  logic [2:0] top_bits,
   input  logic       w_bit,
   output ibp_cls_e   cls,
   output logic       wide
);

   always_comb begin
      case (top_bits)
         3'b000, 3'b001: cls = CLS_RM;
         3'b100, 3'b101: cls = CLS_IMM;
         3'b010:         cls = CLS_OPREG;
         default:        cls = CLS_IMPL;
      endcase
   end

   assign wide = ((cls == CLS_RM) || (cls == CLS_IMM)) ? w_bit : 1'b0;

endmodule

// File: rtl/ibp_seq.sv
module ibp_seq
   import ibp_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [1:0]       mode_in,
   input  ibp_cls_e         cls_in,
   input  logic             wide_in,
   input  logic             rec_ready,
   output logic             in_ready,
   output logic             rec_valid,
   output logic             ld_opc,
   output logic             ld_modrm,
   output logic             ld_dlo,
   output logic             ld_dhi,
   output logic             ld_ilo,
   output logic             ld_ihi,
   output logic [LEN_W-1:0] len_q,
   output logic [FMT_W-1:0] fmt_q,
   output ibp_cls_e         cls_q,
   output logic             wide_q
);

   ibp_state_e st_q, st_d, after_disp;
   logic [1:0] dn_q, dn_now;
   logic       take;
   logic       one_byte_in;

   assign in_ready    = (st_q != ST_DONE);
   assign rec_valid   = (st_q == ST_DONE);
   assign take        = in_valid && in_ready;
   assign dn_now      = disp_count(mode_in);
   assign one_byte_in = (cls_in == CLS_IMPL) || (cls_in == CLS_OPREG);
   assign after_disp  = (cls_q == CLS_IMM) ? ST_ILO : ST_DONE;

   assign ld_opc   = take && (st_q == ST_OPC);
   assign ld_modrm = take && (st_q == ST_MODRM);
   assign ld_dlo   = take && (st_q == ST_DLO);
   assign ld_dhi   = take && (st_q == ST_DHI);
   assign ld_ilo   = take && (st_q == ST_ILO);
   assign ld_ihi   = take && (st_q == ST_IHI);

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_OPC: begin
            if (take) st_d = one_byte_in ? ST_DONE : ST_MODRM;
         end
         ST_MODRM: begin
            if (take) begin
               if (dn_now != 2'd0)       st_d = ST_DLO;
               else if (cls_q == CLS_IMM) st_d = ST_ILO;
               else                       st_d = ST_DONE;
            end
         end
         ST_DLO: begin
            if (take) st_d = (dn_q == 2'd2) ? ST_DHI : after_disp;
         end
         ST_DHI: begin
            if (take) st_d = after_disp;
         end
         ST_ILO: begin
            if (take) st_d = wide_q ? ST_IHI : ST_DONE;
         end
         ST_IHI: begin
            if (take) st_d = ST_DONE;
         end
         ST_DONE: begin
            if (rec_ready) st_d = ST_OPC;
         end
         default: st_d = ST_OPC;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= ST_OPC;
         len_q  <= '0;
         fmt_q  <= FMT_NONE;
         cls_q  <= CLS_IMPL;
         wide_q <= 1'b0;
         dn_q   <= 2'd0;
      end else begin
         st_q <= st_d;
         if (ld_opc) begin
            len_q  <= LEN_W'(1);
            cls_q  <= cls_in;
            wide_q <= wide_in;
            fmt_q  <= FMT_ONE;
            dn_q   <= 2'd0;
         end else if (take) begin
            len_q <= len_q + LEN_W'(1);
         end
         if (ld_modrm) begin
            dn_q  <= dn_now;
            fmt_q <= fmt_for(cls_q, mode_in);
         end
      end
   end

endmodule

// File: rtl/ibp_fields.sv
module ibp_fields #(
   parameter int BYTE_W        = 8,
   parameter int SIGN_EXT_DISP = 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [BYTE_W-1:0]   in_byte,
   input  logic                ld_opc,
   input  logic                ld_modrm,
   input  logic                ld_dlo,
   input  logic                ld_dhi,
   input  logic                ld_ilo,
   input  logic                ld_ihi,
   output logic [BYTE_W-1:0]   opcode_q,
   output logic [BYTE_W-1:0]   modrm_q,
   output logic [2*BYTE_W-1:0] disp_q,
   output logic [2*BYTE_W-1:0] imm_q
);

   localparam int WORD_W = 2 * BYTE_W;

   logic [BYTE_W-1:0] disp_fill;

   // upper half written when a lone displacement byte arrives
   generate
      if (SIGN_EXT_DISP != 0) begin : g_sext
         assign disp_fill = {BYTE_W{in_byte[BYTE_W-1]}};
      end else begin : g_zext
         assign disp_fill = '0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         opcode_q <= '0;
         modrm_q  <= '0;
         disp_q   <= '0;
         imm_q    <= '0;
      end else begin
         if (ld_opc) begin
            opcode_q <= in_byte;
            modrm_q  <= '0;
            disp_q   <= '0;
            imm_q    <= '0;
         end
         if (ld_modrm) modrm_q <= in_byte;
         if (ld_dlo)   disp_q  <= {disp_fill, in_byte};
         if (ld_dhi)   disp_q[WORD_W-1:BYTE_W] <= in_byte;
         if (ld_ilo)   imm_q   <= {{BYTE_W{1'b0}}, in_byte};
         if (ld_ihi)   imm_q[WORD_W-1:BYTE_W]  <= in_byte;
      end
   end

endmodule

// File: rtl/instr_byte_parser.sv
module instr_byte_parser
   import ibp_pkg::*;
#(
   parameter int BYTE_W        = 8,
   parameter int W_BIT         = 0,
   parameter int SIGN_EXT_DISP = 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [BYTE_W-1:0]   in_byte,
   output logic                rec_valid,
   input  logic                rec_ready,
   output logic [2:0]          rec_fmt,
   output logic [2:0]          rec_len,
   output logic [BYTE_W-1:0]   rec_opcode,
   output logic [BYTE_W-1:0]   rec_modrm,
   output logic [2*BYTE_W-1:0] rec_disp,
   output logic [2*BYTE_W-1:0] rec_imm,
   output logic                rec_wide,
   output logic                rec_opreg_en,
   output logic [2:0]          rec_opreg
);

   localparam int TOP_LSB  = BYTE_W - 3;
   localparam int MODE_LSB = BYTE_W - 2;

   initial begin
      if (BYTE_W < 4)
         $fatal(1, "instr_byte_parser: BYTE_W must be at least 4");
      if (W_BIT < 0 || W_BIT >= TOP_LSB)
         $fatal(1, "instr_byte_parser: W_BIT must lie below the class bits");
      if (SIGN_EXT_DISP != 0 && SIGN_EXT_DISP != 1)
         $fatal(1, "instr_byte_parser: SIGN_EXT_DISP must be 0 or 1");
      if (MAX_LEN >= (1 << LEN_W))
         $fatal(1, "instr_byte_parser: length field too narrow");
   end

   ibp_cls_e cls_in, cls_q;
   logic     wide_in, wide_q;
   logic     ld_opc, ld_modrm, ld_dlo, ld_dhi, ld_ilo, ld_ihi;
   logic [LEN_W-1:0] len_q;
   logic [FMT_W-1:0] fmt_q;
   logic [BYTE_W-1:0] opcode_q;

   ibp_classify u_cls (
      .top_bits (in_byte[BYTE_W-1:TOP_LSB]),
      .w_bit    (in_byte[W_BIT]),
      .cls      (cls_in),
      .wide     (wide_in)
   );

   ibp_seq u_seq (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .mode_in   (in_byte[BYTE_W-1:MODE_LSB]),
      .cls_in    (cls_in),
      .wide_in   (wide_in),
      .rec_ready (rec_ready),
      .in_ready  (in_ready),
      .rec_valid (rec_valid),
      .ld_opc    (ld_opc),
      .ld_modrm  (ld_modrm),
      .ld_dlo    (ld_dlo),
      .ld_dhi    (ld_dhi),
      .ld_ilo    (ld_ilo),
      .ld_ihi    (ld_ihi),
      .len_q     (len_q),
      .fmt_q     (fmt_q),
      .cls_q     (cls_q),
      .wide_q    (wide_q)
   );

   ibp_fields #(
      .BYTE_W        (BYTE_W),
      .SIGN_EXT_DISP (SIGN_EXT_DISP)
   ) u_fld (
      .clk      (clk),
      .rst      (rst),
      .in_byte  (in_byte),
      .ld_opc   (ld_opc),
      .ld_modrm (ld_modrm),
      .ld_dlo   (ld_dlo),
      .ld_dhi   (ld_dhi),
      .ld_ilo   (ld_ilo),
      .ld_ihi   (ld_ihi),
      .opcode_q (opcode_q),
      .modrm_q  (rec_modrm),
      .disp_q   (rec_disp),
      .imm_q    (rec_imm)
   );

   assign rec_fmt      = fmt_q;
   assign rec_len      = len_q;
   assign rec_opcode   = opcode_q;
   assign rec_wide     = wide_q;
   assign rec_opreg_en = (cls_q == CLS_OPREG);
   assign rec_opreg    = opcode_q[2:0];

endmodule

// File: rtl/ibp_checker.sv
module ibp_checker #(
   parameter int BYTE_W        = 8,
   parameter int SIGN_EXT_DISP = 1
) (
   input logic                clk,
   input logic                rst,
   input logic                in_valid,
   input logic                in_ready,
   input logic                rec_valid,
   input logic                rec_ready,
   input logic [2:0]          rec_fmt,
   input logic [2:0]          rec_len,
   input logic [BYTE_W-1:0]   rec_opcode,
   input logic [BYTE_W-1:0]   rec_modrm,
   input logic [2*BYTE_W-1:0] rec_disp,
   input logic [2*BYTE_W-1:0] rec_imm,
   input logic                rec_wide,
   input logic                rec_opreg_en
);

   localparam int WORD_W = 2 * BYTE_W;

   p_stall_r9: assert property (@(posedge clk) disable iff (rst)
      rec_valid |-> !in_ready);

   p_hold_r9: assert property (@(posedge clk) disable iff (rst)
      rec_valid && !rec_ready |=> rec_valid && $stable(rec_fmt) && $stable(rec_len)
         && $stable(rec_opcode) && $stable(rec_modrm) && $stable(rec_disp)
         && $stable(rec_imm) && $stable(rec_wide));

   p_release_r10: assert property (@(posedge clk) disable iff (rst)
      rec_valid && rec_ready |=> !rec_valid && in_ready);

   p_idle_r8: assert property (@(posedge clk) disable iff (rst)
      !in_valid && !rec_valid |=> !rec_valid);

   p_one_byte_r3: assert property (@(posedge clk) disable iff (rst)
      rec_valid && rec_fmt == 3'd1 |-> rec_len == 3'd1 && rec_modrm == '0
         && rec_disp == '0 && rec_imm == '0);

   p_opreg_r3: assert property (@(posedge clk) disable iff (rst)
      rec_valid && rec_opreg_en |-> rec_fmt == 3'd1);

   p_two_byte_r4: assert property (@(posedge clk) disable iff (rst)
      rec_valid && (rec_fmt == 3'd2 || rec_fmt == 3'd3) |-> rec_len == 3'd2 && rec_disp == '0);

   p_imm_reg_r6: assert property (@(posedge clk) disable iff (rst)
      rec_valid && rec_fmt == 3'd5 |-> rec_len == (rec_wide ? 3'd4 : 3'd3));

   p_narrow_imm_r6: assert property (@(posedge clk) disable iff (rst)
      rec_valid && (rec_fmt == 3'd5 || rec_fmt == 3'd6) && !rec_wide
         |-> rec_imm[WORD_W-1:BYTE_W] == '0);

   p_imm_mem_r7: assert property (@(posedge clk) disable iff (rst)
      rec_valid && rec_fmt == 3'd6 |-> rec_len >= 3'd3 && rec_len <= 3'd6);

   p_fmt_range_r2: assert property (@(posedge clk) disable iff (rst)
      rec_valid |-> rec_fmt >= 3'd1 && rec_fmt <= 3'd6);

   generate
      if (SIGN_EXT_DISP != 0) begin : g_sx_chk
         p_sext_r5: assert property (@(posedge clk) disable iff (rst)
            rec_valid && rec_fmt == 3'd4 && rec_len == 3'd3
               |-> rec_disp[WORD_W-1:BYTE_W] == {BYTE_W{rec_disp[BYTE_W-1]}});
      end else begin : g_zx_chk
         p_zext_r5: assert property (@(posedge clk) disable iff (rst)
            rec_valid && rec_fmt == 3'd4 && rec_len == 3'd3
               |-> rec_disp[WORD_W-1:BYTE_W] == '0);
      end
   endgenerate

endmodule

bind instr_byte_parser ibp_checker #(
   .BYTE_W        (BYTE_W),
   .SIGN_EXT_DISP (SIGN_EXT_DISP)
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .in_valid     (in_valid),
   .in_ready     (in_ready),
   .rec_valid    (rec_valid),
   .rec_ready    (rec_ready),
   .rec_fmt      (rec_fmt),
   .rec_len      (rec_len),
   .rec_opcode   (rec_opcode),
   .rec_modrm    (rec_modrm),
   .rec_disp     (rec_disp),
   .rec_imm      (rec_imm),
   .rec_wide     (rec_wide),
   .rec_opreg_en (rec_opreg_en)
);

// File: tb/instr_byte_parser_tb_top.sv
module instr_byte_parser_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic        rec_ready = 1'b0;
   logic [7:0]  in_byte = 8'h00;
   logic        in_ready, rec_valid, rec_wide, rec_opreg_en;
   logic [2:0]  rec_fmt, rec_len, rec_opreg;
   logic [7:0]  rec_opcode, rec_modrm;
   logic [15:0] rec_disp, rec_imm;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   instr_byte_parser dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_byte(in_byte), .rec_valid(rec_valid), .rec_ready(rec_ready),
      .rec_fmt(rec_fmt), .rec_len(rec_len), .rec_opcode(rec_opcode),
      .rec_modrm(rec_modrm), .rec_disp(rec_disp), .rec_imm(rec_imm),
      .rec_wide(rec_wide), .rec_opreg_en(rec_opreg_en), .rec_opreg(rec_opreg)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      chk("R8 ready while parsing", {31'd0, in_ready}, 32'd1);
      chk("R8 no record before last byte", {31'd0, rec_valid}, 32'd0);
      in_valid = 1'b1;
      in_byte  = b;
      @(posedge clk);
   endtask

   task automatic gap();
      @(negedge clk);
      in_valid = 1'b0;
      in_byte  = 8'h00;
      @(posedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL R8 watchdog act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0]  opc, modrm, dlo, dhi, ilo, ihi;
      logic [1:0]  mode;
      int          cls, dn, inn, elen, efmt;
      logic        w;
      logic [15:0] edisp, eimm;
      logic [7:0]  bs [6];
      string       tg;

      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset ready", {31'd0, in_ready}, 32'd1);
      chk("R1 reset no record", {31'd0, rec_valid}, 32'd0);
      rst = 1'b0;

      for (int i = 0; i < 1024; i++) begin
         opc  = i[7:0];
         mode = i[9:8];
         case (opc[7:5])
            3'b000, 3'b001: cls = 2;
            3'b100, 3'b101: cls = 3;
            3'b010:         cls = 1;
            default:        cls = 0;
         endcase
         w     = (cls >= 2) ? opc[0] : 1'b0;
         modrm = {mode, i[2:0] ^ 3'b101, i[5:3]};
         dlo   = 8'(i * 37 + 129);
         dhi   = 8'(i * 11 + 3);
         ilo   = 8'(i * 53 + 7);
         ihi   = 8'(i * 29 + 200);
         dn    = (cls >= 2) ? ((mode == 2'b01) ? 1 : (mode == 2'b10) ? 2 : 0) : 0;
         inn   = (cls == 3) ? (w ? 2 : 1) : 0;
         elen  = (cls < 2) ? 1 : 2 + dn + inn;
         if (cls < 2)       efmt = 1;
         else if (cls == 2) efmt = (mode == 2'b11) ? 2 : (mode == 2'b00) ? 3 : 4;
         else               efmt = (mode == 2'b11) ? 5 : 6;
         edisp = (dn == 2) ? {dhi, dlo} : (dn == 1) ? {{8{dlo[7]}}, dlo} : 16'h0;
         eimm  = (inn == 2) ? {ihi, ilo} : (inn == 1) ? {8'h00, ilo} : 16'h0;
         tg    = (cls < 2) ? "R3" : (cls == 2) ? "R4" : (mode == 2'b11) ? "R6" : "R7";

         bs[0] = opc;
         bs[1] = modrm;
         bs[2] = (dn >= 1) ? dlo : ilo;
         bs[3] = (dn == 2) ? dhi : (dn == 1) ? ilo : ihi;
         bs[4] = (dn == 2) ? ilo : ihi;
         bs[5] = ihi;

         for (int k = 0; k < elen; k++) begin
            if (k > 0 && ((i + k) % 4 == 0)) gap();
            send(bs[k]);
         end
         @(negedge clk);
         in_valid = 1'b0;
         chk({tg, " record valid"}, {31'd0, rec_valid}, 32'd1);
         chk("R9 ready low with record", {31'd0, in_ready}, 32'd0);
         chk({tg, " format"}, {29'd0, rec_fmt}, efmt);
         chk({tg, " length"}, {29'd0, rec_len}, elen);
         chk("R2 operation byte", {24'd0, rec_opcode}, {24'd0, opc});
         chk("R2 width bit", {31'd0, rec_wide}, {31'd0, w});
         chk({tg, " addressing byte"}, {24'd0, rec_modrm}, (cls < 2) ? 32'd0 : {24'd0, modrm});
         chk("R5 displacement", {16'd0, rec_disp}, {16'd0, edisp});
         chk((cls == 3) ? "R6 immediate" : "R3 immediate", {16'd0, rec_imm}, {16'd0, eimm});
         chk("R3 register flag", {31'd0, rec_opreg_en}, (cls == 1) ? 32'd1 : 32'd0);
         if (cls == 1)
            chk("R3 register number", {29'd0, rec_opreg}, {29'd0, opc[2:0]});

         if (i % 5 == 0) begin
            in_valid = 1'b1;
            in_byte  = 8'h01;
            repeat (2) begin
               @(posedge clk);
               @(negedge clk);
            end
            in_valid = 1'b0;
            chk("R9 record held", {31'd0, rec_valid}, 32'd1);
            chk("R9 input refused", {31'd0, in_ready}, 32'd0);
            chk("R9 length held", {29'd0, rec_len}, elen);
            chk("R9 displacement held", {16'd0, rec_disp}, {16'd0, edisp});
            chk("R9 immediate held", {16'd0, rec_imm}, {16'd0, eimm});
            chk("R9 operation byte held", {24'd0, rec_opcode}, {24'd0, opc});
         end

         rec_ready = 1'b1;
         @(posedge clk);
         @(negedge clk);
         rec_ready = 1'b0;
         chk("R10 record cleared", {31'd0, rec_valid}, 32'd0);
         chk("R10 ready again", {31'd0, in_ready}, 32'd1);
      end

      // reset in the middle of an instruction
      send(8'h01);
      @(negedge clk);
      in_valid = 1'b0;
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      chk("R1 mid reset ready", {31'd0, in_ready}, 32'd1);
      chk("R1 mid reset no record", {31'd0, rec_valid}, 32'd0);
      send(8'h70);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R1 fresh parse valid", {31'd0, rec_valid}, 32'd1);
      chk("R1 fresh parse format", {29'd0, rec_fmt}, 32'd1);
      chk("R1 fresh parse length", {29'd0, rec_len}, 32'd1);
      chk("R1 fresh parse opcode", {24'd0, rec_opcode}, 32'h70);
      rec_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rec_ready = 1'b0;

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule